// File: doc/BRIEF.md
# Phase-Accumulator Waveform Oscillator

This block is one voice of a digital tone generator. It runs one step per clock cycle. Each step adds a 16-bit frequency word to a 24-bit phase accumulator. From the accumulator it forms a 12-bit waveform sample: sawtooth, triangle or variable-width pulse. A fourth source is noise taken from a 23-bit feedback shift register. The shift register steps each time accumulator bit 19 goes high. An 8-bit readback carries the upper bits of the sample.

Software writes the frequency and pulse-width words one byte lane at a time through separate strobes. A control byte selects the waveform and holds three mode bits:
- a test bit, which freezes and clears the oscillator;
- a ring bit, which lets a neighbour's MSB fold the triangle;
- a sync bit, which lets a neighbour restart this voice's phase.

For chaining, the voice exposes the following to its neighbours:
- its accumulator MSB;
- a one-cycle flag that the MSB is rising;
- a flag that it is itself being hard-synced this cycle.

With these, three voices can be wired in a ring. A source that is being synced in the same cycle does not pass the sync on.

Top module: `wave_osc`

## Requirements
- R1: After a synchronous active-low reset:
  - the accumulator, frequency, pulse width and control fields are zero;
  - the noise register holds 0x7FFFF8;
  - wave_out is 0.
- R2: Each cycle the accumulator adds the frequency word, modulo 2^24. While the test bit (control bit 3) is 1, the accumulator holds its value.
- R3: A control write with bit 3 set clears the accumulator and the noise register. A control write with bit 3 clear, made while the test bit is 1, loads the noise register with 0x7FFFF8.
- R4: Select value 4'b0010 (control bits 7:4) gives the sawtooth, which is accumulator bits 23:12.
- R5: Select value 4'b0001 gives the triangle. It is accumulator bits 22:11, inverted when the fold bit is 1. The fold bit is accumulator bit 23, XORed with src_msb when the ring bit (control bit 2) is set.
- R6: Select value 4'b0100 gives the pulse. It is 0xFFF when the test bit is set or accumulator bits 23:12 are greater than or equal to the pulse width, and 0x000 otherwise.
- R7: Select value 4'b1000 gives the noise output.
  - When accumulator bit 19 goes from 0 to 1, the noise register shifts left by one, keeps 23 bits, and takes bit 22 XOR bit 17 as its new bit 0.
  - Output bits 11..4 are register bits 22, 20, 16, 13, 11, 7, 4, 2 in that order. Output bits 3..0 are zero.
- R8: Select value 0, and every select value with more than one bit set, gives wave_out = 0.
- R9: wave_rd equals wave_out bits 11:4.
- R10:
  - acc_msb_o is accumulator bit 23.
  - msb_rise_o is 1 in a cycle where the test bit is clear, bit 23 is 0, and bit 23 of the accumulator plus the frequency word is 1.
- R11: Hard sync.
  - sync_req_o is the sync bit (control bit 1) AND src_msb_rise.
  - When sync_req_o is 1 and src_syncing is 0, the accumulator loads 0 at the next edge instead of its sum. When src_syncing is 1, no sync occurs.
- R12: Byte-lane writes.
  - freq_lo_we and freq_hi_we write frequency bits 7:0 and 15:8 from wr_data[7:0].
  - pw_lo_we writes pulse-width bits 7:0 from wr_data[7:0]. pw_hi_we writes bits 11:8 from wr_data[3:0].
  - Each strobe leaves the other lane unchanged. A write takes effect from the next cycle's addition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock, one oscillator step per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| freq_lo_we | input | 1 | Write strobe, frequency low byte |
| freq_hi_we | input | 1 | Write strobe, frequency high byte |
| pw_lo_we | input | 1 | Write strobe, pulse-width low byte |
| pw_hi_we | input | 1 | Write strobe, pulse-width high nibble |
| ctrl_we | input | 1 | Write strobe, control byte |
| wr_data | input | 8 | Write data shared by all strobes |
| src_msb | input | 1 | Accumulator MSB of the sync/ring source voice |
| src_msb_rise | input | 1 | Source voice MSB rising this cycle |
| src_syncing | input | 1 | Source voice is itself being hard-synced this cycle |
| wave_out | output | 12 | Selected waveform sample |
| wave_rd | output | 8 | Upper eight bits of the sample |
| acc_msb_o | output | 1 | Accumulator MSB, for neighbours |
| msb_rise_o | output | 1 | Accumulator MSB rises at the coming edge |
| sync_req_o | output | 1 | This voice is being synced this cycle |

## Verification
The bench keeps an independent model. A wrong accumulator shows on the sawtooth and on acc_msb_o in the cycle after the bad edge. It also shifts the timing of every later msb_rise_o pulse.

A wrong noise register stays hidden until noise is selected. Once it is, the error shows in every later noise sample, because the feedback carries it forward.

The bench also checks the cycle-exact boundaries:
- pulse width against a phase that climbs by one unit per cycle;
- test entry and release;
- hard sync with the source both free and itself being synced.

// File: rtl/osc_pkg.sv
// Shared widths, control-byte layout and noise tap positions for the oscillator.
package osc_pkg;

    localparam int unsigned DEF_ACC_W   = 24;
    localparam int unsigned DEF_FREQ_W  = 16;
    localparam int unsigned DEF_PW_W    = 12;
    localparam int unsigned DEF_OUT_W   = 12;
    localparam int unsigned DEF_LFSR_W  = 23;
    localparam int unsigned NOISE_CLK_OFS = 5;   // noise steps on bit ACC_W-NOISE_CLK_OFS
    localparam int unsigned FB_TAP_HI   = 22;
    localparam int unsigned FB_TAP_LO   = 17;
    localparam logic [DEF_LFSR_W-1:0] LFSR_SEED = 23'h7FFFF8;
    localparam int unsigned NOISE_BITS  = 8;

    // Register bit feeding noise output bit (OUT_W-NOISE_BITS+i), lowest first.
    localparam int unsigned NOISE_POS [NOISE_BITS] = '{2, 4, 7, 11, 13, 16, 20, 22};

    // Waveform select codes (one-hot; anything else is silent).
    localparam logic [3:0] SEL_TRI   = 4'b0001;
    localparam logic [3:0] SEL_SAW   = 4'b0010;
    localparam logic [3:0] SEL_PULSE = 4'b0100;
    localparam logic [3:0] SEL_NOISE = 4'b1000;

    // Control byte bits 7:1; bit 0 is not used by this block.
    typedef struct packed {
        logic [3:0] sel;
        logic       test;
        logic       ring;
        logic       sync;
    } osc_ctrl_t;

endpackage

// File: rtl/osc_regs.sv
// Byte-lane register bank: frequency word, pulse width and control fields.
// Assumes at most one strobe is meaningful per cycle; if several are high,
// each updates its own lane independently.
module osc_regs #(
    parameter int unsigned FREQ_W = osc_pkg::DEF_FREQ_W,
    parameter int unsigned PW_W   = osc_pkg::DEF_PW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              freq_lo_we,
    input  logic              freq_hi_we,
    input  logic              pw_lo_we,
    input  logic              pw_hi_we,
    input  logic              ctrl_we,
    input  logic [7:0]        data,
    output logic [FREQ_W-1:0] freq,
    output logic [PW_W-1:0]   pw,
    output osc_pkg::osc_ctrl_t ctrl
);
    localparam int unsigned FREQ_HI_W = FREQ_W - 8;
    localparam int unsigned PW_HI_W   = PW_W - 8;

    // Frequency word lanes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            freq <= '0;
        end else begin
            if (freq_lo_we) freq[7:0] <= data;
            if (freq_hi_we) freq[FREQ_W-1:8] <= data[FREQ_HI_W-1:0];
        end
    end

    // Pulse-width lanes; the high lane keeps only its low bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pw <= '0;
        end else begin
            if (pw_lo_we) pw[7:0] <= data;
            if (pw_hi_we) pw[PW_W-1:8] <= data[PW_HI_W-1:0];
        end
    end

    // Control fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (ctrl_we) begin
            ctrl <= data[7:1];
        end
    end

endmodule

// File: rtl/osc_phase.sv
// Phase accumulator. Adds the frequency word each cycle unless held, loads
// zero on a clear request, and flags the MSB rising and the noise clock bit
// rising for the coming edge. Clear wins over hold and add.
module osc_phase #(
    parameter int unsigned ACC_W  = osc_pkg::DEF_ACC_W,
    parameter int unsigned FREQ_W = osc_pkg::DEF_FREQ_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FREQ_W-1:0] freq,
    input  logic              hold,
    input  logic              clr,
    output logic [ACC_W-1:0]  acc,
    output logic              msb_rise,
    output logic              noise_tick
);
    localparam int unsigned TICK_BIT = ACC_W - osc_pkg::NOISE_CLK_OFS;

    logic [ACC_W-1:0] sum;

    // Next phase value, modulo 2^ACC_W.
    always_comb begin
        sum = acc + {{(ACC_W-FREQ_W){1'b0}}, freq};
    end

    // Edge flags for the MSB and the noise clock bit.
    always_comb begin
        msb_rise   = !hold && !acc[ACC_W-1]  && sum[ACC_W-1];
        noise_tick = !hold && !acc[TICK_BIT] && sum[TICK_BIT];
    end

    // Accumulator register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (clr) begin
            acc <= '0;
        end else if (!hold) begin
            acc <= sum;
        end
    end

endmodule

// File: rtl/osc_noise.sv
// Fibonacci shift register for the noise source. Clear beats seed load,
// which beats a step. Exposes the tapped output bits.
module osc_noise #(
    parameter int unsigned LFSR_W = osc_pkg::DEF_LFSR_W
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             step,
    input  logic                             clr,
    input  logic                             seed_ld,
    output logic [LFSR_W-1:0]                state,
    output logic [osc_pkg::NOISE_BITS-1:0]   taps
);
    logic fb;

    // Feedback bit from the two taps.
    always_comb begin
        fb = state[osc_pkg::FB_TAP_HI] ^ state[osc_pkg::FB_TAP_LO];
    end

    // Shift register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= osc_pkg::LFSR_SEED;
        end else if (clr) begin
            state <= '0;
        end else if (seed_ld) begin
            state <= osc_pkg::LFSR_SEED;
        end else if (step) begin
            state <= {state[LFSR_W-2:0], fb};
        end
    end

    // Scattered output taps.
    for (genvar i = 0; i < osc_pkg::NOISE_BITS; i++) begin : g_tap
        assign taps[i] = state[osc_pkg::NOISE_POS[i]];
    end

endmodule

// File: rtl/osc_shaper.sv
// Combinational waveform former. Takes the top OUT_W+1 phase bits, forms
// triangle, sawtooth, pulse and noise, and passes the one selected.
// Anything that is not a single select bit gives silence.
module osc_shaper #(
    parameter int unsigned OUT_W = osc_pkg::DEF_OUT_W,
    parameter int unsigned PW_W  = osc_pkg::DEF_PW_W
) (
    input  logic [OUT_W:0]                 phase,
    input  logic [osc_pkg::NOISE_BITS-1:0] noise_taps,
    input  logic [PW_W-1:0]                pw,
    input  logic [3:0]                     sel,
    input  logic                           test,
    input  logic                           ring,
    input  logic                           src_msb,
    output logic [OUT_W-1:0]               wave
);
    localparam int unsigned NOISE_PAD = OUT_W - osc_pkg::NOISE_BITS;

    logic             fold;
    logic [OUT_W-1:0] tri_w, saw_w, pul_w, noi_w;

    // Individual waveforms.
    always_comb begin
        fold  = phase[OUT_W] ^ (ring & src_msb);
        tri_w = fold ? ~phase[OUT_W-1:0] : phase[OUT_W-1:0];
        saw_w = phase[OUT_W:1];
        pul_w = (test || (phase[OUT_W:1] >= pw)) ? '1 : '0;
        noi_w = {noise_taps, {NOISE_PAD{1'b0}}};
    end

    // Waveform select.
    always_comb begin
        unique case (sel)
            osc_pkg::SEL_TRI:   wave = tri_w;
            osc_pkg::SEL_SAW:   wave = saw_w;
            osc_pkg::SEL_PULSE: wave = pul_w;
            osc_pkg::SEL_NOISE: wave = noi_w;
            default:            wave = '0;
        endcase
    end

endmodule

// File: rtl/wave_osc.sv
// Single-voice phase-accumulator oscillator. Joins the register bank,
// accumulator, noise register and shaper, and forms the hard-sync and
// test-bit control. Assumes the src_* inputs come from the neighbouring
// voice's outputs in the same cycle.
module wave_osc #(
    parameter int unsigned ACC_W  = osc_pkg::DEF_ACC_W,
    parameter int unsigned FREQ_W = osc_pkg::DEF_FREQ_W,
    parameter int unsigned PW_W   = osc_pkg::DEF_PW_W,
    parameter int unsigned OUT_W  = osc_pkg::DEF_OUT_W,
    parameter int unsigned LFSR_W = osc_pkg::DEF_LFSR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             freq_lo_we,
    input  logic             freq_hi_we,
    input  logic             pw_lo_we,
    input  logic             pw_hi_we,
    input  logic             ctrl_we,
    input  logic [7:0]       wr_data,
    input  logic             src_msb,
    input  logic             src_msb_rise,
    input  logic             src_syncing,
    output logic [OUT_W-1:0] wave_out,
    output logic [7:0]       wave_rd,
    output logic             acc_msb_o,
    output logic             msb_rise_o,
    output logic             sync_req_o
);
    localparam int unsigned TEST_BIT = 3;

    logic [FREQ_W-1:0]          freq;
    logic [PW_W-1:0]            pw;
    osc_pkg::osc_ctrl_t         ctrl;
    logic [ACC_W-1:0]           acc_q;
    logic [LFSR_W-1:0]          lfsr_q;
    logic [osc_pkg::NOISE_BITS-1:0] noise_taps;
    logic                       test_q, sync_q;
    logic [3:0]                 sel_q;
    logic                       test_enter, test_leave, sync_clear, noise_tick;

    // Control-derived events for this cycle.
    always_comb begin
        test_q     = ctrl.test;
        sync_q     = ctrl.sync;
        sel_q      = ctrl.sel;
        test_enter = ctrl_we &&  wr_data[TEST_BIT];
        test_leave = ctrl_we && !wr_data[TEST_BIT] && test_q;
        sync_req_o = sync_q && src_msb_rise;
        sync_clear = sync_req_o && !src_syncing;
    end

    osc_regs #(.FREQ_W(FREQ_W), .PW_W(PW_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .freq_lo_we (freq_lo_we),
        .freq_hi_we (freq_hi_we),
        .pw_lo_we   (pw_lo_we),
        .pw_hi_we   (pw_hi_we),
        .ctrl_we    (ctrl_we),
        .data       (wr_data),
        .freq       (freq),
        .pw         (pw),
        .ctrl       (ctrl)
    );

    osc_phase #(.ACC_W(ACC_W), .FREQ_W(FREQ_W)) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .freq       (freq),
        .hold       (test_q),
        .clr        (test_enter || sync_clear),
        .acc        (acc_q),
        .msb_rise   (msb_rise_o),
        .noise_tick (noise_tick)
    );

    osc_noise #(.LFSR_W(LFSR_W)) u_noise (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (noise_tick),
        .clr     (test_enter),
        .seed_ld (test_leave),
        .state   (lfsr_q),
        .taps    (noise_taps)
    );

    osc_shaper #(.OUT_W(OUT_W), .PW_W(PW_W)) u_shaper (
        .phase      (acc_q[ACC_W-1 -: OUT_W+1]),
        .noise_taps (noise_taps),
        .pw         (pw),
        .sel        (sel_q),
        .test       (test_q),
        .ring       (ctrl.ring),
        .src_msb    (src_msb),
        .wave       (wave_out)
    );

    // Readback and neighbour-facing MSB.
    always_comb begin
        wave_rd   = wave_out[OUT_W-1 -: 8];
        acc_msb_o = acc_q[ACC_W-1];
    end

endmodule

// File: rtl/wave_osc_chk.sv
// Assertion checker for wave_osc, bound into every instance. Watches the
// accumulator, noise register and control fields against the ports.
module wave_osc_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ctrl_we,
    input logic        wr_test,
    input logic        src_msb_rise,
    input logic        src_syncing,
    input logic        msb_rise_o,
    input logic        acc_msb_o,
    input logic [osc_pkg::DEF_OUT_W-1:0]  wave_out,
    input logic [osc_pkg::DEF_ACC_W-1:0]  acc_q,
    input logic [osc_pkg::DEF_LFSR_W-1:0] lfsr_q,
    input logic        test_q,
    input logic        sync_q,
    input logic [3:0]  sel_q
);
    assert_hold_in_test_R2: assert property (@(posedge clk) disable iff (!rst_n)
        test_q |=> $stable(acc_q));

    assert_test_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && wr_test) |=> (acc_q == '0 && lfsr_q == '0));

    assert_test_release_seed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && !wr_test && test_q) |=> (lfsr_q == osc_pkg::LFSR_SEED));

    assert_pulse_in_test_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (test_q && sel_q == osc_pkg::SEL_PULSE) |-> (wave_out == '1));

    assert_bad_sel_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(sel_q) != 1) |-> (wave_out == '0));

    assert_rise_from_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        msb_rise_o |-> !acc_msb_o);

    assert_sync_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (src_msb_rise && sync_q && !src_syncing) |=> (acc_q == '0));

endmodule

bind wave_osc wave_osc_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctrl_we      (ctrl_we),
    .wr_test      (wr_data[3]),
    .src_msb_rise (src_msb_rise),
    .src_syncing  (src_syncing),
    .msb_rise_o   (msb_rise_o),
    .acc_msb_o    (acc_msb_o),
    .wave_out     (wave_out),
    .acc_q        (acc_q),
    .lfsr_q       (lfsr_q),
    .test_q       (test_q),
    .sync_q       (sync_q),
    .sel_q        (sel_q)
);

// File: tb/wave_osc_bench.sv
// Self-checking bench: a cycle model built from the requirements runs
// beside the design and every output is compared at each falling edge.
module wave_osc_bench;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic freq_lo_we = 0, freq_hi_we = 0, pw_lo_we = 0, pw_hi_we = 0, ctrl_we = 0;
    logic [7:0] wr_data = '0;
    logic src_msb = 0, src_msb_rise = 0, src_syncing = 0;
    logic [11:0] wave_out;
    logic [7:0]  wave_rd;
    logic acc_msb_o, msb_rise_o, sync_req_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    wave_osc u_wave_osc (
        .clk(clk), .rst_n(rst_n),
        .freq_lo_we(freq_lo_we), .freq_hi_we(freq_hi_we),
        .pw_lo_we(pw_lo_we), .pw_hi_we(pw_hi_we), .ctrl_we(ctrl_we),
        .wr_data(wr_data), .src_msb(src_msb), .src_msb_rise(src_msb_rise),
        .src_syncing(src_syncing), .wave_out(wave_out), .wave_rd(wave_rd),
        .acc_msb_o(acc_msb_o), .msb_rise_o(msb_rise_o), .sync_req_o(sync_req_o)
    );

    // Reference state.
    logic [23:0] m_acc;
    logic [15:0] m_freq;
    logic [11:0] m_pw;
    logic [3:0]  m_sel;
    logic        m_test, m_ring, m_sync;
    logic [22:0] m_lfsr;
    int checks = 0, fails = 0;
    string phase_tag = "R1";

    task automatic model_reset();
        m_acc = '0; m_freq = '0; m_pw = '0; m_sel = '0;
        m_test = 0; m_ring = 0; m_sync = 0; m_lfsr = 23'h7FFFF8;
    endtask

    // One reference step using the inputs present at the rising edge.
    task automatic model_step();
        logic [23:0] sum, n_acc;
        logic [22:0] n_lfsr;
        sum = m_acc + {8'h00, m_freq};
        n_acc = m_acc; n_lfsr = m_lfsr;
        if (!m_test) begin
            if (!m_acc[19] && sum[19]) n_lfsr = {m_lfsr[21:0], m_lfsr[22] ^ m_lfsr[17]};
            n_acc = sum;
        end
        if (src_msb_rise && m_sync && !src_syncing) n_acc = '0;
        if (freq_lo_we) m_freq[7:0]  = wr_data;
        if (freq_hi_we) m_freq[15:8] = wr_data;
        if (pw_lo_we)   m_pw[7:0]    = wr_data;
        if (pw_hi_we)   m_pw[11:8]   = wr_data[3:0];
        if (ctrl_we) begin
            if (wr_data[3]) begin n_acc = '0; n_lfsr = '0; end
            else if (m_test) n_lfsr = 23'h7FFFF8;
            m_sel = wr_data[7:4]; m_test = wr_data[3];
            m_ring = wr_data[2]; m_sync = wr_data[1];
        end
        m_acc = n_acc; m_lfsr = n_lfsr;
    endtask

    function automatic logic [11:0] exp_wave();
        logic f;
        f = m_acc[23] ^ (m_ring & src_msb);
        case (m_sel)
            4'b0001: return f ? ~m_acc[22:11] : m_acc[22:11];
            4'b0010: return m_acc[23:12];
            4'b0100: return (m_test || m_acc[23:12] >= m_pw) ? 12'hFFF : 12'h000;
            4'b1000: return {m_lfsr[22], m_lfsr[20], m_lfsr[16], m_lfsr[13],
                             m_lfsr[11], m_lfsr[7], m_lfsr[4], m_lfsr[2], 4'h0};
            default: return 12'h000;
        endcase
    endfunction

    function automatic string sel_tag();
        case (m_sel)
            4'b0001: return "R5";
            4'b0010: return "R4";
            4'b0100: return "R6";
            4'b1000: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(string tag, logic [23:0] act, logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s [%s] act=%h exp=%h at %0t", tag, phase_tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        logic [23:0] s;
        logic [11:0] w;
        s = m_acc + {8'h00, m_freq};
        w = exp_wave();
        chk({sel_tag(), " wave_out"}, {12'h0, wave_out}, {12'h0, w});
        chk("R9 wave_rd", {16'h0, wave_rd}, {16'h0, w[11:4]});
        chk("R10 acc_msb_o", {23'h0, acc_msb_o}, {23'h0, m_acc[23]});
        chk("R10 msb_rise_o", {23'h0, msb_rise_o}, {23'h0, !m_test && !m_acc[23] && s[23]});
        chk("R11 sync_req_o", {23'h0, sync_req_o}, {23'h0, m_sync && src_msb_rise});
    endtask

    // Advance n cycles: step the model at each rising edge, compare at the falling one.
    task automatic cyc(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            model_step();
            @(negedge clk);
            compare_all();
            freq_lo_we = 0; freq_hi_we = 0; pw_lo_we = 0; pw_hi_we = 0; ctrl_we = 0;
            src_msb_rise = 0; src_syncing = 0;
        end
    endtask

    task automatic wr_freq(logic [15:0] v);
        freq_lo_we = 1; wr_data = v[7:0]; cyc(1);
        freq_hi_we = 1; wr_data = v[15:8]; cyc(1);
    endtask

    task automatic wr_pw(logic [11:0] v);
        pw_lo_we = 1; wr_data = v[7:0]; cyc(1);
        pw_hi_we = 1; wr_data = {4'hA, v[11:8]}; cyc(1);
    endtask

    task automatic wr_ctrl(logic [7:0] v);
        ctrl_we = 1; wr_data = v; cyc(1);
    endtask

    // Watchdog.
    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1: reset state.
        phase_tag = "R1";
        compare_all();
        chk("R1 wave_out zero", {12'h0, wave_out}, 24'h0);
        wr_ctrl(8'h80);
        chk("R1 noise seed", {12'h0, wave_out}, 24'h000FE0);

        // R2, R4, R12: sawtooth climbs by the written word.
        phase_tag = "R12";
        wr_freq(16'h1234);
        wr_ctrl(8'h20);
        phase_tag = "R2";
        cyc(300);
        phase_tag = "R12";
        freq_hi_we = 1; wr_data = 8'h7E; cyc(1);   // only high lane changes
        cyc(50);
        freq_lo_we = 1; wr_data = 8'h05; cyc(1);   // only low lane changes
        cyc(50);

        // Sweep all select values, both ring settings, with a toggling neighbour MSB.
        for (int sel = 0; sel < 16; sel++) begin
            for (int rg = 0; rg < 2; rg++) begin
                phase_tag = "sweep";
                wr_freq(16'h0400 + 16'(sel * 16'h0731) + 16'(rg * 16'h2222));
                wr_pw(12'(12'h300 + sel * 12'h0B1));
                wr_ctrl({4'(sel), 1'b0, 1'(rg), 2'b00});
                for (int k = 0; k < 64; k++) begin
                    src_msb = k[3];
                    cyc(1);
                end
            end
        end
        src_msb = 0;

        // R3: enter test clears, pulse forced high; leave test reseeds noise.
        phase_tag = "R3";
        wr_ctrl(8'h48);
        cyc(10);
        chk("R3 pulse in test", {12'h0, wave_out}, 24'h000FFF);
        wr_ctrl(8'h20);
        cyc(20);
        wr_ctrl(8'h88);
        chk("R3 noise cleared", {12'h0, wave_out}, 24'h0);
        wr_ctrl(8'h80);
        chk("R3 noise reseeded", {12'h0, wave_out}, 24'h000FE0);

        // R7: long noise run at the fastest rate.
        phase_tag = "R7";
        wr_freq(16'hFFFF);
        cyc(3000);

        // R6: pulse boundary; phase top climbs by one per cycle from zero.
        phase_tag = "R6";
        wr_pw(12'h005);
        wr_freq(16'h1000);
        wr_ctrl(8'h48);
        wr_ctrl(8'h40);
        cyc(12);
        wr_pw(12'hFFF);
        cyc(40);

        // R11: hard sync, free source then source itself being synced.
        phase_tag = "R11";
        wr_freq(16'h1234);
        wr_ctrl(8'h22);
        cyc(20);
        src_msb_rise = 1; cyc(1);
        chk("R11 sync cleared", {12'h0, wave_out}, 24'h0);
        cyc(20);
        src_msb_rise = 1; src_syncing = 1; cyc(1);
        cyc(20);
        wr_ctrl(8'h20);
        src_msb_rise = 1; cyc(1);                      // sync bit clear: no effect
        cyc(20);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule